// File: doc/BRIEF.md
# Bit Vector Index Compressor

This engine walks a bit vector stored in byte-addressed memory and writes the signed position of every set bit into consecutive 32-bit slots of a vector register file. Software supplies an operand base address, a signed starting bit index, a signed bit count and a starting element slot. A section size parameter caps how many slots one pass may fill. Each pass returns the next bit index, the bits still to scan, the number of filled slots and a 2-bit condition code. A program then loops pass by pass, once per section, until the bit count is used up.

Within a byte, bit index offset 0 is the most significant bit. The byte address is the base plus the bit index shifted right arithmetically by three. This lets a negative index reach bytes below the base. The engine keeps the last byte it fetched and reads memory again only when it moves into a new byte. It can halt at the top of its loop when asked and report a resumable state. A later start with those values picks up where it left off.

Top module: `bitidx_compress`

## Requirements
- R1: For each set bit scanned, the element written equals that bit's 32-bit index. It goes to slot `vix`, and `vix` then increments. Clear bits write nothing, so the element values rise from slot to slot.
- R2: Bit index low bits 0 select byte bit 7 and low bits 7 select byte bit 0.
- R3: The read address is `base_addr + (bix >>> 3)` modulo 2^ADDR_W, so a negative index addresses bytes below the base.
- R4: A start with a bit count of zero or less issues no read and writes no element. It completes with vector count equal to the starting slot, and the index and count unchanged.
- R5: When the slot index reaches SECT, the pass ends with vector count SECT. Bit index and bit count then name the next unscanned bit and the bits left.
- R6: On completion, slot index output is 0 and vector count is the slot index at the end. Bit index equals start plus bits scanned, and bit count equals start minus bits scanned.
- R7: Condition code: 0 means vector count 0 and bit count 0. 1 means vector count 0 and bit count negative. 2 means vector count SECT and bit count positive. 3 covers every other completion.
- R8: With `intr_req` high at the loop top and the pass not finished, the engine raises `done` with `interrupted`. It returns a bit index, count and slot that, fed back with a new start, yield the same element set as an uninterrupted pass.
- R9: One byte read per byte touched in a pass. `rd_valid` holds with a stable `rd_addr` until `rd_ready`.
- R10: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse, and all handshake outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin a pass |
| base_addr | input | ADDR_W | Operand byte base address |
| bix_in | input | 32 | Signed starting bit index |
| bcnt_in | input | 32 | Signed bit count |
| vix_in | input | VIX_W | Starting element slot |
| intr_req | input | 1 | Request a stop at the next loop top |
| rd_valid | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_ready | input | 1 | Read accepted, data present |
| rd_data | input | 8 | Read byte |
| el_we | output | 1 | Element write strobe |
| el_idx | output | VIX_W | Element slot |
| el_data | output | 32 | Element value (bit index) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass ended (completion or interrupt) |
| interrupted | output | 1 | Pass ended early and is resumable |
| bix_out | output | 32 | Next bit index |
| bcnt_out | output | 32 | Bits remaining |
| vct_out | output | VIX_W | Vector count |
| vix_out | output | VIX_W | Element slot after the pass |
| cc_out | output | 2 | Condition code |

## Verification
The bench sweeps starting indices from negative to positive across byte borders, bit counts from negative through larger than a section, and every starting slot up to a full section. Memory stalls at random. A wrong in-byte bit order or a logical rather than arithmetic shift would produce wrong element values or read the wrong bytes for negative indices. An off-by-one at the section limit would overrun slot SECT-1 or return code 3 where 2 is due. Interrupted passes that are restarted must rebuild the same slot contents, which catches a design that saves a half-advanced index or rescans a bit.

// File: rtl/bitidx_pkg.sv
package bitidx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TOP, ST_FETCH, ST_TEST} bx_state_e;
  localparam logic [1:0] CC_EMPTY_ZERO = 2'd0;
  localparam logic [1:0] CC_EMPTY_NEG  = 2'd1;
  localparam logic [1:0] CC_FULL_MORE  = 2'd2;
  localparam logic [1:0] CC_LAST       = 2'd3;
endpackage

// File: rtl/bitidx_cc.sv
module bitidx_cc
  import bitidx_pkg::*;
#(
  parameter int SECT  = 16,
  parameter int VIX_W = 5
) (
  input  logic [VIX_W-1:0] vct,
  input  logic [31:0]      bcnt,
  output logic [1:0]       cc
);
  localparam logic [VIX_W-1:0] SECT_V = VIX_W'(SECT);

  always_comb begin
    if (vct == '0) begin
      cc = ($signed(bcnt) == 0) ? CC_EMPTY_ZERO : CC_EMPTY_NEG;
    end else if ((vct == SECT_V) && ($signed(bcnt) > 0)) begin
      cc = CC_FULL_MORE;
    end else begin
      cc = CC_LAST;
    end
  end
endmodule

// File: rtl/bitidx_fetch.sv
module bitidx_fetch #(
  parameter int ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] base,
  input  logic [31:0]       bix,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [7:0]        rd_data,
  output logic              got,
  output logic              bit_val
);
  logic signed [31:0] byte_off;
  logic [7:0]         byte_q, byte_d;
  logic [2:0]         sel;

  always_comb begin
    byte_off = $signed(bix) >>> 3;
    rd_addr  = base + byte_off[ADDR_W-1:0];
    rd_valid = req;
    got      = req & rd_ready;
    byte_d   = got ? rd_data : byte_q;
    sel      = 3'd7 - bix[2:0];
    bit_val  = byte_q[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_q <= '0;
    else        byte_q <= byte_d;
  end

  // R9: a pending read keeps its address
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
endmodule

// File: rtl/bitidx_seq.sv
module bitidx_seq
  import bitidx_pkg::*;
#(
  parameter int SECT  = 16,
  parameter int VIX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      bix_in,
  input  logic [31:0]      bcnt_in,
  input  logic [VIX_W-1:0] vix_in,
  input  logic             intr_req,
  input  logic             got,
  input  logic             bit_val,
  output logic             fetch_req,
  output logic [31:0]      bix,
  output logic [31:0]      bcnt,
  output logic [VIX_W-1:0] vix,
  output logic [VIX_W-1:0] vct,
  output logic             el_we,
  output logic [VIX_W-1:0] el_idx,
  output logic [31:0]      el_data,
  output logic             busy,
  output logic             done,
  output logic             interrupted
);
  localparam logic [VIX_W-1:0] SECT_V = VIX_W'(SECT);

  bx_state_e          st_q, st_d;
  logic signed [31:0] bix_q, bix_d, bcnt_q, bcnt_d;
  logic [VIX_W-1:0]   vix_q, vix_d, vct_q, vct_d;
  logic               have_q, have_d, done_q, done_d, intr_q, intr_d;

  always_comb begin
    st_d   = st_q;
    bix_d  = bix_q;
    bcnt_d = bcnt_q;
    vix_d  = vix_q;
    vct_d  = vct_q;
    have_d = have_q;
    done_d = 1'b0;
    intr_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          bix_d  = $signed(bix_in);
          bcnt_d = $signed(bcnt_in);
          vix_d  = vix_in;
          have_d = 1'b0;
          st_d   = ST_TOP;
        end
      end
      ST_TOP: begin
        vct_d = vix_q;
        if ((vix_q == SECT_V) || (bcnt_q <= 0)) begin
          vix_d  = '0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (intr_req) begin
          done_d = 1'b1;
          intr_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (!have_q) begin
          st_d = ST_FETCH;
        end else begin
          st_d = ST_TEST;
        end
      end
      ST_FETCH: begin
        if (got) begin
          have_d = 1'b1;
          st_d   = ST_TEST;
        end
      end
      ST_TEST: begin
        if (bit_val) vix_d = vix_q + 1'b1;
        bix_d  = bix_q + 32'sd1;
        bcnt_d = bcnt_q - 32'sd1;
        if (bix_q[2:0] == 3'd7) have_d = 1'b0;
        st_d   = ST_TOP;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bix_q  <= '0;
      bcnt_q <= '0;
      vix_q  <= '0;
      vct_q  <= '0;
      have_q <= 1'b0;
      done_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bix_q  <= bix_d;
      bcnt_q <= bcnt_d;
      vix_q  <= vix_d;
      vct_q  <= vct_d;
      have_q <= have_d;
      done_q <= done_d;
      intr_q <= intr_d;
    end
  end

  always_comb begin
    fetch_req   = (st_q == ST_FETCH);
    el_we       = (st_q == ST_TEST) && bit_val;
    el_idx      = vix_q;
    el_data     = bix_q;
    bix         = bix_q;
    bcnt        = bcnt_q;
    vix         = vix_q;
    vct         = vct_q;
    busy        = (st_q != ST_IDLE);
    done        = done_q;
    interrupted = intr_q;
  end

  // tracking of the last element written, used by a_r1 only
  logic               seen_q;
  logic signed [31:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (start && !busy) begin
      seen_q <= 1'b0;
    end else if (el_we) begin
      seen_q <= 1'b1;
      last_q <= $signed(el_data);
    end
  end

  a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    el_we && seen_q |-> $signed(el_data) > last_q);
  a_r1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    el_we |-> el_idx < SECT_V);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done && !interrupted |-> vix == '0 && !busy);
  a_r5_vct_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vct <= SECT_V);
endmodule

// File: rtl/bitidx_compress.sv
module bitidx_compress #(
  parameter  int ADDR_W = 31,
  parameter  int SECT   = 16,
  localparam int VIX_W  = $clog2(SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       bix_in,
  input  logic [31:0]       bcnt_in,
  input  logic [VIX_W-1:0]  vix_in,
  input  logic              intr_req,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [7:0]        rd_data,
  output logic              el_we,
  output logic [VIX_W-1:0]  el_idx,
  output logic [31:0]       el_data,
  output logic              busy,
  output logic              done,
  output logic              interrupted,
  output logic [31:0]       bix_out,
  output logic [31:0]       bcnt_out,
  output logic [VIX_W-1:0]  vct_out,
  output logic [VIX_W-1:0]  vix_out,
  output logic [1:0]        cc_out
);
  logic fetch_req, got, bit_val;

  bitidx_seq #(.SECT(SECT), .VIX_W(VIX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bix_in(bix_in), .bcnt_in(bcnt_in), .vix_in(vix_in),
    .intr_req(intr_req), .got(got), .bit_val(bit_val),
    .fetch_req(fetch_req), .bix(bix_out), .bcnt(bcnt_out),
    .vix(vix_out), .vct(vct_out), .el_we(el_we), .el_idx(el_idx),
    .el_data(el_data), .busy(busy), .done(done),
    .interrupted(interrupted)
  );

  bitidx_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .req(fetch_req), .base(base_addr),
    .bix(bix_out), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .got(got), .bit_val(bit_val)
  );

  bitidx_cc #(.SECT(SECT), .VIX_W(VIX_W)) u_cc (
    .vct(vct_out), .bcnt(bcnt_out), .cc(cc_out)
  );

  // R7: code 2 only with a full section and bits left
  a_r7_full_code: assert property (@(posedge clk) disable iff (!rst_n)
    done && !interrupted && cc_out == 2'd2 |->
      vct_out == VIX_W'(SECT) && $signed(bcnt_out) > 0);
  // R4: no read may start while idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !el_we);
endmodule

// File: tb/sim_bitidx_compress.sv
`timescale 1ns/1ps
module sim_bitidx_compress;
  localparam int SS = 4;
  localparam int VW = $clog2(SS + 1);
  localparam int AW = 31;
  localparam int BASE = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = AW'(BASE);
  logic [31:0]   bix_in = '0, bcnt_in = '0;
  logic [VW-1:0] vix_in = '0;
  logic          intr_req = 1'b0, intr_en = 1'b0;
  logic          rd_valid, rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          el_we, busy, done, interrupted;
  logic [VW-1:0] el_idx, vct_out, vix_out;
  logic [31:0]   el_data, bix_out, bcnt_out;
  logic [1:0]    cc_out;

  logic [7:0]  mem [0:63];
  logic [15:0] lfsr = 16'hACE1;
  int nchk = 0, nfail = 0;
  bit finished = 0;
  int got_el [0:7];
  int got_n, rd_n;
  int exp_el [0:7];
  int exp_bix, exp_bcnt, exp_vct, exp_cc, exp_reads;

  always #5 clk = ~clk;

  assign rd_data = mem[rd_addr[5:0]];

  bitidx_compress #(.ADDR_W(AW), .SECT(SS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .bix_in(bix_in), .bcnt_in(bcnt_in), .vix_in(vix_in),
    .intr_req(intr_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .el_we(el_we),
    .el_idx(el_idx), .el_data(el_data), .busy(busy), .done(done),
    .interrupted(interrupted), .bix_out(bix_out), .bcnt_out(bcnt_out),
    .vct_out(vct_out), .vix_out(vix_out), .cc_out(cc_out)
  );

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = lfsr[1] | lfsr[4];
    intr_req = intr_en & lfsr[3] & lfsr[7] & lfsr[9];
  end

  always @(negedge clk) begin
    #2;
    if (el_we) begin
      got_el[el_idx] = $signed(el_data);
      got_n++;
    end
    if (rd_valid && rd_ready) rd_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int b0, input int c0, input int v0);
    int b = b0, c = c0, v = v0;
    bit first = 1;
    logic [7:0] byt;
    exp_reads = 0;
    forever begin
      exp_vct = v;
      if (v == SS || c <= 0) break;
      if (first || (b & 7) == 0) exp_reads++;
      first = 0;
      byt = mem[(BASE + (b >>> 3)) & 63];
      if (byt[7 - (b & 7)]) begin
        exp_el[v] = b;
        v++;
      end
      b++;
      c--;
    end
    exp_bix = b;
    exp_bcnt = c;
    if (exp_vct == 0) exp_cc = (c == 0) ? 0 : 1;
    else if (exp_vct == SS && c > 0) exp_cc = 2;
    else exp_cc = 3;
  endtask

  task automatic run(input int b0, input int c0, input int v0,
                     input bit use_intr, input string tag);
    int cb = b0, cc = c0, cv = v0, rounds = 0, to;
    bit ok;
    model(b0, c0, v0);
    for (int k = 0; k < 8; k++) got_el[k] = 32'h7fff_fff0;
    got_n = 0;
    rd_n = 0;
    intr_en = use_intr;
    forever begin
      @(negedge clk);
      start = 1'b1;
      bix_in = cb;
      bcnt_in = cc;
      vix_in = VW'(cv);
      @(negedge clk);
      start = 1'b0;
      if (rounds == 0) chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      to = 0;
      while (!done && to < 3000) begin
        @(negedge clk);
        to++;
      end
      if (!done) begin
        chk(0, "R10 done timeout", to, 0);
        intr_en = 0;
        return;
      end
      if (interrupted) begin
        cb = $signed(bix_out);
        cc = $signed(bcnt_out);
        cv = int'(vix_out);
        rounds++;
        if (rounds > 300) intr_en = 0;
        continue;
      end
      break;
    end
    intr_en = 0;
    chk(busy == 1'b0, "R10 idle at done", int'(busy), 0);
    ok = (got_n == exp_vct - v0);
    for (int k = v0; k < exp_vct; k++) ok &= (got_el[k] == exp_el[k]);
    chk(ok, {tag, " R1 elements"}, got_n, exp_vct - v0);
    chk($signed(bix_out) == exp_bix, "R6 bit index", $signed(bix_out), exp_bix);
    chk($signed(bcnt_out) == exp_bcnt, "R6 bit count", $signed(bcnt_out), exp_bcnt);
    chk(int'(vct_out) == exp_vct, "R6 vector count", int'(vct_out), exp_vct);
    chk(vix_out == '0, "R6 slot cleared", int'(vix_out), 0);
    chk(int'(cc_out) == exp_cc, "R7 condition code", int'(cc_out), exp_cc);
    if (!use_intr) chk(rd_n == exp_reads, "R9 read count", rd_n, exp_reads);
    if (c0 <= 0) chk(got_n == 0 && rd_n == 0, "R4 no work", got_n + rd_n, 0);
    if (exp_cc == 2) chk(int'(vct_out) == SS, "R5 section full", int'(vct_out), SS);
    @(negedge clk);
    chk(done == 1'b0, "R10 done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cnts [0:6];
    cnts = '{-2, -1, 0, 1, 5, 13, 40};
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 73 + 29) ^ (i * 5));
    mem[32] = 8'b0100_0110;
    mem[33] = 8'b1000_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_valid && !el_we, "R10 reset state",
        int'({busy, done, rd_valid, el_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // pattern 010001101 from index 0 gives 1,5,6,8
    run(0, 9, 0, 0, "R2 example");
    chk(got_el[0] == 1 && got_el[1] == 5 && got_el[2] == 6 && got_el[3] == 8,
        "R1 R2 example values", got_el[3], 8);
    chk(int'(cc_out) == 3, "R7 example code", int'(cc_out), 3);
    for (int k = 0; k < 2; k++)
      mem[32 + k] = 8'(((32 + k) * 73 + 29) ^ ((32 + k) * 5));
    for (int b = -20; b <= 20; b += 3)
      for (int ci = 0; ci < 7; ci++)
        for (int v = 0; v <= SS; v++)
          run(b, cnts[ci], v, ((b + ci + v) % 3) == 0,
              (b < 0) ? "R3 R8 negative index" : "R2 R8 sweep");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule